// File: doc/BRIEF.md
# Byte-Qualified Read Parity Checker

This block guards a 64-bit data path that carries one even-parity bit per byte. On the write side it computes the parity byte for the outgoing data in the same clock as the data. On the read side it looks at the returned data on every clock in which the active-low ready strobe is low. Only the bytes selected by the active-low byte enables are checked. The result reaches an active-low status output with a fixed latency of two clocks, and each strobe clock gets its own report, so a burst of back-to-back strobes loses no error.

When the active-low check-enable input is low in a clock where an error is found, the block records the address and control of the cycle in a single machine-check record. The record keeps the first such error until a clear input empties it. If the global machine-check enable is high in the clock of the capture, the block also raises an exception request, which stays high with the record.

The record is kept by a three-state machine. `SLOT_EMPTY` holds nothing. `SLOT_LOGGED` holds an error without a request. `SLOT_RAISED` holds an error with the request raised. The transitions are as follows:
- **take-quiet** goes from `SLOT_EMPTY` to `SLOT_LOGGED`. It fires on a capture while the enable is low.
- **take-raise** goes from `SLOT_EMPTY` to `SLOT_RAISED`. It fires on a capture while the enable is high.
- **release** goes from either full state to `SLOT_EMPTY`. It fires on a clear with no capture.
- **retake** goes from either full state to `SLOT_LOGGED` or `SLOT_RAISED`. It fires on a clear together with a capture in the same clock.

Top module: `dpar_guard`

## Requirements
- R1: `wr_par[i]` is, in the same clock, the XOR of `wr_data[8i+7:8i]`, so that each byte plus its parity bit holds an even count of ones. Bit 7 belongs to bits 63..56 and bit 0 to bits 7..0.
- R2: A read byte is in error when the XOR of its 8 data bits differs from its `rd_par` bit. Errors are looked at only in clocks where `rdy_n` is 0. Bad parity with `rdy_n` at 1 produces no report.
- R3: A byte whose `byte_en_n` bit is 1 never causes a report or a capture, whatever its parity.
- R4: An error in strobe clock T drives `pchk_n` low during clock T+2 only. In every clock not so marked, `pchk_n` is 1.
- R5: Errors in consecutive strobe clocks each give their own low clock of `pchk_n`, two clocks later, with none merged or dropped.
- R6: An error in a clock where `chk_en_n` is 0 and the record is empty loads `cyc_addr` and `cyc_ctl` into `mc_addr`/`mc_ctl` and sets `mc_valid` from the next clock on. An error with `chk_en_n` at 1 captures nothing.
- R7: While `mc_valid` is 1 and `mc_clear` is 0, later errors leave `mc_valid`, `mc_addr` and `mc_ctl` unchanged.
- R8: `mc_req` becomes 1 together with `mc_valid` when `mce_on` was 1 in the capture clock, and stays 0 otherwise. It is never 1 without `mc_valid`.
- R9: `mc_clear` empties the record from the next clock on: `mc_valid` and `mc_req` go to 0 and `mc_addr`/`mc_ctl` go to zero. A capture in the same clock as the clear is kept as the new record.
- R10: After reset, `pchk_n` is 1, `mc_valid` and `mc_req` are 0, and `mc_addr`/`mc_ctl` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 64 | Outgoing write data |
| wr_par | output | 8 | Even parity per byte of `wr_data` |
| rd_data | input | 64 | Returned read data |
| rd_par | input | 8 | Returned parity, one bit per byte |
| byte_en_n | input | 8 | Byte enables of the cycle, active low |
| rdy_n | input | 1 | Ready strobe, active low |
| chk_en_n | input | 1 | Capture enable, active low |
| mce_on | input | 1 | Global machine-check enable |
| cyc_addr | input | 29 | Address of the current cycle |
| cyc_ctl | input | 4 | Control attributes of the current cycle |
| mc_clear | input | 1 | Empties the machine-check record |
| pchk_n | output | 1 | Parity status, active low, two clocks late |
| mc_valid | output | 1 | Record holds an error |
| mc_req | output | 1 | Machine-check exception request |
| mc_addr | output | 29 | Recorded address |
| mc_ctl | output | 4 | Recorded control |

## Verification
The write parity is combinational and is due in the same clock as `wr_data`. The status for a strobe clock is due two rising edges later. The record and request change one edge after the capture or clear clock. The bench drives inputs on the falling edge. At each rising edge its model consumes the same inputs: it pushes the error flag into a queue whose head becomes the status two edges on, and it applies the capture and clear rules to its own record. The bench then compares all outputs 2 ns after that edge, so every result is read in the clock in which it is due.

// File: rtl/dpar_pkg.sv
package dpar_pkg;

    localparam int BYTE_W     = 8;
    localparam int REPORT_LAT = 2;

    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_LOGGED = 2'd1,
        SLOT_RAISED = 2'd2
    } mc_state_e;

endpackage

// File: rtl/dpar_gen.sv
module dpar_gen #(
    parameter int NBYTES = 8
) (
    input  logic [NBYTES*8-1:0] data,
    output logic [NBYTES-1:0]   par
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign par[g] = ^data[g*8 +: 8];
    end
endmodule

// File: rtl/dpar_chk.sv
module dpar_chk #(
    parameter int NBYTES = 8
) (
    input  logic [NBYTES*8-1:0] rd_data,
    input  logic [NBYTES-1:0]   rd_par,
    input  logic [NBYTES-1:0]   be_n,
    input  logic                strobe,
    output logic                err
);
    logic [NBYTES-1:0] calc;
    logic [NBYTES-1:0] bad;

    dpar_gen #(.NBYTES(NBYTES)) u_gen (
        .data (rd_data),
        .par  (calc)
    );

    // a byte counts only when it was requested
    assign bad = (calc ^ rd_par) & ~be_n;
    assign err = strobe & (|bad);
endmodule

// File: rtl/dpar_pipe.sv
module dpar_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_in,
    output logic flag_out_n
);
    logic [LAT-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr[0] <= flag_in;
            for (int i = 1; i < LAT; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    assign flag_out_n = ~sr[LAT-1];
endmodule

// File: rtl/dpar_mcr.sv
module dpar_mcr
    import dpar_pkg::*;
#(
    parameter int AW = 29,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err,
    input  logic          en_n,
    input  logic          mce_on,
    input  logic          clr,
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] ctl_in,
    output logic          mc_valid,
    output logic          mc_req,
    output logic [AW-1:0] mc_addr,
    output logic [CW-1:0] mc_ctl
);
    mc_state_e state_q, state_d;
    logic      take;
    logic      load;

    assign take = err & ~en_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (take) state_d = mce_on ? SLOT_RAISED : SLOT_LOGGED;
            end
            SLOT_LOGGED, SLOT_RAISED: begin
                if (clr) begin
                    if (take) state_d = mce_on ? SLOT_RAISED : SLOT_LOGGED;
                    else      state_d = SLOT_EMPTY;
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    assign load = take & ((state_q == SLOT_EMPTY) | clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_addr <= '0;
            mc_ctl  <= '0;
        end else if (load) begin
            mc_addr <= addr_in;
            mc_ctl  <= ctl_in;
        end else if (clr) begin
            mc_addr <= '0;
            mc_ctl  <= '0;
        end
    end

    always_comb begin
        mc_valid = (state_q != SLOT_EMPTY);
        mc_req   = (state_q == SLOT_RAISED);
    end

    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_valid && !clr) |=> (mc_valid && $stable(mc_addr) && $stable(mc_ctl))); // R7
    AST_REQ_NEEDS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        mc_req |-> mc_valid); // R8
    AST_GATED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_valid && !(err && !en_n)) |=> !mc_valid); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(err && !en_n)) |=> (!mc_valid && !mc_req)); // R9
endmodule

// File: rtl/dpar_guard.sv
module dpar_guard
    import dpar_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 29,
    parameter int CTL_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W/BYTE_W-1:0] wr_par,
    input  logic [DATA_W-1:0]        rd_data,
    input  logic [DATA_W/BYTE_W-1:0] rd_par,
    input  logic [DATA_W/BYTE_W-1:0] byte_en_n,
    input  logic                     rdy_n,
    input  logic                     chk_en_n,
    input  logic                     mce_on,
    input  logic [ADDR_W-1:0]        cyc_addr,
    input  logic [CTL_W-1:0]         cyc_ctl,
    input  logic                     mc_clear,
    output logic                     pchk_n,
    output logic                     mc_valid,
    output logic                     mc_req,
    output logic [ADDR_W-1:0]        mc_addr,
    output logic [CTL_W-1:0]         mc_ctl
);
    localparam int NB = DATA_W / BYTE_W;

    logic err_now;

    dpar_gen #(.NBYTES(NB)) u_wgen (
        .data (wr_data),
        .par  (wr_par)
    );

    dpar_chk #(.NBYTES(NB)) u_chk (
        .rd_data (rd_data),
        .rd_par  (rd_par),
        .be_n    (byte_en_n),
        .strobe  (~rdy_n),
        .err     (err_now)
    );

    dpar_pipe #(.LAT(REPORT_LAT)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_in    (err_now),
        .flag_out_n (pchk_n)
    );

    dpar_mcr #(.AW(ADDR_W), .CW(CTL_W)) u_mcr (
        .clk      (clk),
        .rst_n    (rst_n),
        .err      (err_now),
        .en_n     (chk_en_n),
        .mce_on   (mce_on),
        .clr      (mc_clear),
        .addr_in  (cyc_addr),
        .ctl_in   (cyc_ctl),
        .mc_valid (mc_valid),
        .mc_req   (mc_req),
        .mc_addr  (mc_addr),
        .mc_ctl   (mc_ctl)
    );

    AST_REPORT_TWO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        err_now |-> ##2 !pchk_n); // R4
    AST_QUIET_WITHOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !err_now |-> ##2 pchk_n); // R2
    AST_IDLE_STROBE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_n |-> !err_now); // R2
endmodule

// File: tb/test_dpar_guard.sv
module test_dpar_guard;
    localparam int DW = 64;
    localparam int NB = 8;
    localparam int AW = 29;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] wr_data, rd_data;
    logic [NB-1:0] wr_par, rd_par, byte_en_n;
    logic          rdy_n, chk_en_n, mce_on, mc_clear;
    logic [AW-1:0] cyc_addr, mc_addr;
    logic [CW-1:0] cyc_ctl, mc_ctl;
    logic          pchk_n, mc_valid, mc_req;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R10";

    bit            q[$];
    bit            m_valid, m_req, e_now, cap;
    logic [AW-1:0] m_addr;
    logic [CW-1:0] m_ctl;
    logic [DW-1:0] d;

    always #4 clk = ~clk;

    dpar_guard i_dpar_guard (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_par(wr_par),
        .rd_data(rd_data), .rd_par(rd_par), .byte_en_n(byte_en_n),
        .rdy_n(rdy_n), .chk_en_n(chk_en_n), .mce_on(mce_on),
        .cyc_addr(cyc_addr), .cyc_ctl(cyc_ctl), .mc_clear(mc_clear),
        .pchk_n(pchk_n), .mc_valid(mc_valid), .mc_req(mc_req),
        .mc_addr(mc_addr), .mc_ctl(mc_ctl)
    );

    function automatic logic [NB-1:0] mkpar(logic [DW-1:0] v);
        logic [NB-1:0] p;
        for (int i = 0; i < NB; i++) p[i] = ^v[i*8 +: 8];
        return p;
    endfunction

    function automatic bit ref_err();
        if (rdy_n) return 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (!byte_en_n[i] && ((^rd_data[i*8 +: 8]) != rd_par[i])) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check1(string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    task automatic put(logic [DW-1:0] dd, logic [NB-1:0] pp, logic [NB-1:0] ben,
                       bit rdy, bit en, bit mce, logic [AW-1:0] a, logic [CW-1:0] c, bit clr);
        @(negedge clk);
        wr_data   = {$urandom, $urandom};
        rd_data   = dd;
        rd_par    = pp;
        byte_en_n = ben;
        rdy_n     = rdy;
        chk_en_n  = en;
        mce_on    = mce;
        cyc_addr  = a;
        cyc_ctl   = c;
        mc_clear  = clr;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) put('0, '0, '1, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0);
    endtask

    // reference model and per-clock comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_valid = 1'b0; m_req = 1'b0; m_addr = '0; m_ctl = '0;
        end else begin
            e_now = ref_err();
            cap   = e_now && !chk_en_n;
            if (mc_clear) begin
                m_valid = 1'b0; m_req = 1'b0; m_addr = '0; m_ctl = '0;
            end
            if (cap && !m_valid) begin
                m_valid = 1'b1; m_req = mce_on; m_addr = cyc_addr; m_ctl = cyc_ctl;
            end
            q.push_back(e_now);
            if (q.size() > 2) void'(q.pop_front());
            #2;
            if (rst_n) begin
                check1("pchk_n (R4)", 64'(pchk_n), 64'((q.size() == 2) ? !q[0] : 1'b1));
                check1("mc_valid (R6)", 64'(mc_valid), 64'(m_valid));
                check1("mc_req (R8)", 64'(mc_req), 64'(m_req));
                check1("mc_addr (R7)", 64'(mc_addr), 64'(m_addr));
                check1("mc_ctl (R7)", 64'(mc_ctl), 64'(m_ctl));
                check1("wr_par (R1)", 64'(wr_par), 64'(mkpar(wr_data)));
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wr_data = '0; rd_data = '0; rd_par = '0; byte_en_n = '1; rdy_n = 1'b1;
        chk_en_n = 1'b1; mce_on = 1'b0; cyc_addr = '0; cyc_ctl = '0; mc_clear = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R10 reset state
        check1("reset pchk_n (R10)", 64'(pchk_n), 64'd1);
        check1("reset mc_valid (R10)", 64'(mc_valid), 64'd0);
        check1("reset mc_req (R10)", 64'(mc_req), 64'd0);
        check1("reset mc_addr (R10)", 64'(mc_addr), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        idle(6);

        phase = "R2";   // bad parity without strobe
        d = {$urandom, $urandom};
        put(d, ~mkpar(d), '0, 1'b1, 1'b0, 1'b0, 29'h11, 4'h1, 1'b0);
        put(d, ~mkpar(d), '0, 1'b1, 1'b0, 1'b1, 29'h12, 4'h2, 1'b0);
        idle(3);

        phase = "R3";   // bad byte masked off
        d = {$urandom, $urandom};
        put(d, mkpar(d) ^ 8'h20, 8'h20, 1'b0, 1'b0, 1'b1, 29'h13, 4'h3, 1'b0);
        put(d, mkpar(d) ^ 8'h01, 8'hFF, 1'b0, 1'b0, 1'b1, 29'h14, 4'h4, 1'b0);
        put(d, mkpar(d), 8'h00, 1'b0, 1'b0, 1'b1, 29'h15, 4'h5, 1'b0);
        idle(3);

        phase = "R4";   // single error, top byte, no capture
        d = {$urandom, $urandom};
        put(d, mkpar(d) ^ 8'h80, 8'h00, 1'b0, 1'b1, 1'b0, 29'h16, 4'h6, 1'b0);
        idle(4);

        phase = "R5";   // back-to-back burst
        for (int k = 0; k < 4; k++) begin
            d = {$urandom, $urandom};
            put(d, mkpar(d) ^ ((k == 1) ? 8'h00 : (8'h01 << k)), 8'h00, 1'b0, 1'b1, 1'b0,
                29'h20 + 29'(k), 4'h7, 1'b0);
        end
        idle(4);

        phase = "R6";   // gated then enabled capture
        d = {$urandom, $urandom};
        put(d, mkpar(d) ^ 8'h04, 8'h00, 1'b0, 1'b1, 1'b1, 29'h0AAAA, 4'h8, 1'b0);
        idle(2);
        put(d, mkpar(d) ^ 8'h04, 8'h00, 1'b0, 1'b0, 1'b0, 29'h1B0B0, 4'h9, 1'b0);
        idle(2);

        phase = "R7";   // second error must not overwrite
        put(d, mkpar(d) ^ 8'h10, 8'h00, 1'b0, 1'b0, 1'b1, 29'h0C0C0, 4'hA, 1'b0);
        idle(2);

        phase = "R9";
        put('0, '0, '1, 1'b1, 1'b1, 1'b0, '0, '0, 1'b1);
        idle(2);

        phase = "R8";   // capture with request
        put(d, mkpar(d) ^ 8'h40, 8'h00, 1'b0, 1'b0, 1'b1, 29'h0D0D0, 4'hB, 1'b0);
        idle(2);

        phase = "R9";   // clear and capture in one clock
        put(d, mkpar(d) ^ 8'h02, 8'h00, 1'b0, 1'b0, 1'b0, 29'h0E0E0, 4'hC, 1'b1);
        idle(2);
        put('0, '0, '1, 1'b1, 1'b1, 1'b0, '0, '0, 1'b1);
        idle(3);

        summary();
        $finish;
    end
endmodule